// File: doc/BRIEF.md
# Line Rescaler with Lanczos3 Interpolation and Pair Averaging

This block resizes one line of 8-bit luminance samples at a time. In enlarge mode every input sample produces two output samples. One output sits on the input grid and the other sits halfway between two inputs. The halfway sample is a six-tap weighted sum whose weights come from a small per-phase Lanczos3 table. In shrink mode each pair of neighbouring inputs is averaged into one output. The result is a line twice as long or half as long as the input.

Samples arrive on a valid/ready stream. The block first gathers a full line of `LINE_LEN` samples and then delivers that line's outputs on a second valid/ready stream. Feeding it rows gives horizontal scaling, and feeding it columns of a block gives vertical scaling. The direction input is taken together with the first sample of each line.

Top module: `rs_line_rescaler`

## Requirements
- R1: After reset the block accepts input (`in_ready_o` = 1) and presents no output (`out_valid_o` = 0).
- R2: A line is exactly `LINE_LEN` (default 8) accepted samples. After the last one, `in_ready_o` stays 0 and `out_valid_o` stays 1 until every output of that line has been taken. Then `in_ready_o` returns to 1 with `out_valid_o` at 0. The two are never high together.
- R3: In enlarge mode (`mode_down_i` = 0) a line yields 2*`LINE_LEN` outputs in order k = 0, 1, 2, ... Output k = 2i equals input sample i.
- R4: In enlarge mode output k = 2i+1 is the sum over t = 0..5 of w[t]*x[i-2+t], with w = (13, -70, 313, 313, -70, 13). The sum of the weights is 512. Adding 256 and shifting right by 9 gives the result.
- R5: A tap index below 0 reads sample 0, and a tap index above `LINE_LEN`-1 reads the last sample.
- R6: An interpolated value below 0 is output as 0, and a value above 255 is output as 255.
- R7: In shrink mode (`mode_down_i` = 1) a line yields `LINE_LEN`/2 outputs. Output j is (x[2j] + x[2j+1] + 1) >> 1.
- R8: The mode is taken from `mode_down_i` only when the first sample of a line is accepted. Changing it later in the line has no effect on that line.
- R9: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_data_o` holds its value and `out_valid_o` stays 1.
- R10: `in_valid_i` and `in_data_i` are ignored while `in_ready_o` = 0. Samples offered then are not taken into any line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_down_i | input | 1 | 0 = enlarge 2x, 1 = shrink 2x; taken with a line's first sample |
| in_valid_i | input | 1 | Input sample offered |
| in_ready_o | output | 1 | Block accepts an input sample |
| in_data_i | input | 8 | Input luminance sample |
| out_valid_o | output | 1 | Output sample present |
| out_ready_i | input | 1 | Consumer takes the output sample |
| out_data_o | output | 8 | Output luminance sample |

## Verification
Clipping and edge replication are the hardest cases to reach from the ports. Both need sample patterns with sharp steps, placed either at the very ends of the line or between strong neighbours. The stimulus includes a step line whose interpolated values overshoot above 255, a notch line whose values undershoot below 0, and a line with extreme values at both ends, and it checks every output against a model built from the requirements. A mode flip in the middle of a line, an irregular stall pattern on the output, and junk samples offered during emission cover the behaviour that must be ignored.

// File: rtl/rs_pkg.sv
package rs_pkg;

  localparam int PIX_W     = 8;
  localparam int TAPS      = 6;
  localparam int CTR_TAP   = 2;
  localparam int COEF_W    = 11;
  localparam int FRAC_BITS = 9;
  localparam int ACC_W     = 24;
  localparam int PIX_MAX   = (1 << PIX_W) - 1;

  typedef enum logic {
    MODE_UP   = 1'b0,
    MODE_DOWN = 1'b1
  } scale_mode_e;

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_EMIT = 1'b1
  } seq_state_e;

  // Phase-indexed kernel table: phase 0 is a unit impulse on the centre tap,
  // phase 1 is the Lanczos3 kernel sampled at half-sample offsets.
  function automatic logic signed [COEF_W-1:0] kernel_coef(input logic half_phase,
                                                           input int   tap);
    logic signed [COEF_W-1:0] c;
    c = '0;
    if (!half_phase) begin
      if (tap == CTR_TAP) c = COEF_W'(1 << FRAC_BITS);
    end else begin
      case (tap)
        0, 5:    c = COEF_W'(13);
        1, 4:    c = COEF_W'(-70);
        2, 3:    c = COEF_W'(313);
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/rs_line_buf.sv
module rs_line_buf
  import rs_pkg::*;
#(
  parameter int LINE_LEN = 8,
  localparam int SEL_W   = $clog2(LINE_LEN)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [SEL_W-1:0]                 waddr_i,
  input  logic [PIX_W-1:0]                 wdata_i,
  output logic [LINE_LEN-1:0][PIX_W-1:0]   line_o
);

  logic [LINE_LEN-1:0][PIX_W-1:0] mem_q;
  logic [LINE_LEN-1:0][PIX_W-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we_i) mem_d[waddr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (we_i) mem_q <= mem_d;
  end

  assign line_o = mem_q;

endmodule

// File: rtl/rs_lanczos_fir.sv
module rs_lanczos_fir
  import rs_pkg::*;
#(
  parameter int LINE_LEN = 8,
  localparam int SEL_W   = $clog2(LINE_LEN),
  localparam int IDX_W   = SEL_W + 1
) (
  input  logic [LINE_LEN-1:0][PIX_W-1:0] line_i,
  input  logic [IDX_W-1:0]               out_idx_i,
  output logic [PIX_W-1:0]               pix_o
);

  localparam int ROUND = 1 << (FRAC_BITS - 1);

  logic                     half_phase;
  logic [SEL_W-1:0]         center;
  logic signed [ACC_W-1:0]  prod [TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;

  assign half_phase = out_idx_i[0];
  assign center     = out_idx_i[IDX_W-1:1];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [PIX_W-1:0] smp;
    always_comb begin
      int pos;
      pos = int'(center) + t - CTR_TAP;
      if (pos < 0)             pos = 0;
      if (pos > LINE_LEN - 1)  pos = LINE_LEN - 1;
      smp = line_i[SEL_W'(pos)];
    end
    assign prod[t] = ACC_W'($signed({1'b0, smp})) * ACC_W'(kernel_coef(half_phase, t));
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + prod[t];
    scaled = (acc + ACC_W'(ROUND)) >>> FRAC_BITS;
    if (scaled < 0)                    pix_o = '0;
    else if (scaled > ACC_W'(PIX_MAX)) pix_o = PIX_W'(PIX_MAX);
    else                               pix_o = scaled[PIX_W-1:0];
  end

endmodule

// File: rtl/rs_pair_avg.sv
module rs_pair_avg
  import rs_pkg::*;
#(
  parameter int LINE_LEN = 8,
  localparam int SEL_W   = $clog2(LINE_LEN),
  localparam int PAIR_W  = SEL_W - 1
) (
  input  logic [LINE_LEN-1:0][PIX_W-1:0] line_i,
  input  logic [PAIR_W-1:0]              pair_idx_i,
  output logic [PIX_W-1:0]               pix_o
);

  logic [PIX_W-1:0] even_pix;
  logic [PIX_W-1:0] odd_pix;
  logic [PIX_W:0]   pair_sum;

  assign even_pix = line_i[{pair_idx_i, 1'b0}];
  assign odd_pix  = line_i[{pair_idx_i, 1'b1}];
  assign pair_sum = {1'b0, even_pix} + {1'b0, odd_pix} + (PIX_W+1)'(1);
  assign pix_o    = pair_sum[PIX_W:1];

endmodule

// File: rtl/rs_line_rescaler.sv
module rs_line_rescaler
  import rs_pkg::*;
#(
  parameter int LINE_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_down_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o
);

  localparam int SEL_W   = $clog2(LINE_LEN);
  localparam int PAIR_W  = SEL_W - 1;
  localparam int CNT_W   = SEL_W + 1;
  localparam int UP_OUTS = 2 * LINE_LEN;
  localparam int DN_OUTS = LINE_LEN / 2;

  seq_state_e  state_q, state_d;
  scale_mode_e mode_q,  mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_out;
  logic             in_fire;

  logic [LINE_LEN-1:0][PIX_W-1:0] line_w;
  logic [PIX_W-1:0] fir_pix;
  logic [PIX_W-1:0] avg_pix;

  assign in_ready_o  = (state_q == ST_FILL);
  assign out_valid_o = (state_q == ST_EMIT);
  assign in_fire     = in_ready_o && in_valid_i;
  assign last_out    = (mode_q == MODE_UP) ? CNT_W'(UP_OUTS - 1) : CNT_W'(DN_OUTS - 1);

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    case (state_q)
      ST_FILL: begin
        if (in_valid_i) begin
          if (cnt_q == '0) mode_d = scale_mode_e'(mode_down_i);
          if (cnt_q == CNT_W'(LINE_LEN - 1)) begin
            state_d = ST_EMIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (out_ready_i) begin
          if (cnt_q == last_out) begin
            state_d = ST_FILL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
      mode_q  <= MODE_UP;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  rs_line_buf #(.LINE_LEN(LINE_LEN)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (in_fire),
    .waddr_i (cnt_q[SEL_W-1:0]),
    .wdata_i (in_data_i),
    .line_o  (line_w)
  );

  rs_lanczos_fir #(.LINE_LEN(LINE_LEN)) u_fir (
    .line_i    (line_w),
    .out_idx_i (cnt_q),
    .pix_o     (fir_pix)
  );

  rs_pair_avg #(.LINE_LEN(LINE_LEN)) u_avg (
    .line_i     (line_w),
    .pair_idx_i (cnt_q[PAIR_W-1:0]),
    .pix_o      (avg_pix)
  );

  assign out_data_o = (mode_q == MODE_UP) ? fir_pix : avg_pix;

  // Assertions
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o)); // R2

  AST_EMIT_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> (cnt_q == '0)); // R2

  AST_PHASE0_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && mode_q == MODE_UP && !cnt_q[0]) |->
      (out_data_o == line_w[cnt_q[CNT_W-1:1]])); // R3

  AST_AVG_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && mode_q == MODE_DOWN) |->
      ((out_data_o >= line_w[{cnt_q[PAIR_W-1:0], 1'b0}] ||
        out_data_o >= line_w[{cnt_q[PAIR_W-1:0], 1'b1}]) &&
       (out_data_o <= line_w[{cnt_q[PAIR_W-1:0], 1'b0}] ||
        out_data_o <= line_w[{cnt_q[PAIR_W-1:0], 1'b1}]))); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> $stable(mode_q)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R9

endmodule

// File: tb/rs_line_rescaler_tb_top.sv
module rs_line_rescaler_tb_top;

  localparam int N = 8;
  typedef logic [7:0] line_t [N];

  logic       clk;
  logic       rst_n;
  logic       mode_down;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  rs_line_rescaler #(.LINE_LEN(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_down_i (mode_down),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void check(input bit ok, input string req, input string what,
                                input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic int tap(input line_t p, input int idx);
    int q;
    q = idx < 0 ? 0 : (idx > N-1 ? N-1 : idx);
    return int'(p[q]);
  endfunction

  // expected output and the requirement it exercises
  function automatic int model_up(input line_t p, input int k, output string req);
    int i, v;
    i = k / 2;
    if (k % 2 == 0) begin
      req = "R3";
      return int'(p[i]);
    end
    v = 13*tap(p,i-2) - 70*tap(p,i-1) + 313*tap(p,i) + 313*tap(p,i+1)
        - 70*tap(p,i+2) + 13*tap(p,i+3) + 256;
    if (i - 2 < 0 || i + 3 > N - 1) req = "R5"; else req = "R4";
    if (v < 0) begin req = "R6"; return 0; end
    v = v / 512;
    if (v > 255) begin req = "R6"; return 255; end
    return v;
  endfunction

  task automatic push_line(input bit m, input line_t p, input bit flip_mode);
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = p[s];
      mode_down = (s == 0) ? m : (flip_mode ? !m : m);
      while (!in_ready) @(negedge clk);
    end
  endtask

  task automatic pull_line(input bit m, input line_t p, input bit stall,
                           input bit junk, input string tag);
    int    n, got, cyc, exp;
    bit    was_stalled;
    logic [7:0] held;
    string req;
    n = m ? N/2 : 2*N;
    got = 0; cyc = 0; was_stalled = 0; held = '0;
    while (got < n) begin
      @(negedge clk);
      in_valid  = junk;
      in_data   = 8'hEE;
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      check(!in_ready && out_valid, "R2", "emission handshake", {in_ready, out_valid}, 1);
      if (was_stalled)
        check(out_data == held, "R9", "held data under stall", out_data, held);
      if (out_ready) begin
        if (m) begin
          exp = (int'(p[2*got]) + int'(p[2*got+1]) + 1) / 2;
          req = "R7";
        end else begin
          exp = model_up(p, got, req);
        end
        if (tag != "") req = tag;
        check(int'(out_data) == exp, req, $sformatf("output %0d", got), out_data, exp);
        got++;
        was_stalled = 0;
      end else begin
        was_stalled = 1;
        held = out_data;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R2", "line end returns to input", {in_ready, out_valid}, 2);
  endtask

  task automatic run_line(input bit m, input line_t p, input bit flip, input bit stall,
                          input bit junk, input string tag);
    push_line(m, p, flip);
    pull_line(m, p, stall, junk, tag);
  endtask

  task automatic test_reset;
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic test_up_ramp;
    line_t p = '{10, 40, 70, 100, 130, 160, 190, 220};
    run_line(1'b0, p, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic test_up_edges;   // R5: extreme values at both line ends
    line_t p = '{250, 5, 120, 60, 90, 30, 200, 3};
    run_line(1'b0, p, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic test_clip;       // R6: overshoot and undershoot
    line_t hi = '{0, 0, 0, 255, 255, 0, 0, 0};
    line_t lo = '{255, 255, 255, 0, 0, 255, 255, 255};
    run_line(1'b0, hi, 1'b0, 1'b0, 1'b0, "");
    run_line(1'b0, lo, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic test_down;       // R7: odd sums round up
    line_t p = '{1, 2, 100, 101, 255, 254, 0, 255};
    run_line(1'b1, p, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic test_mode_latch; // R8: mid-line flips in both directions
    line_t p = '{17, 33, 80, 9, 140, 141, 77, 66};
    run_line(1'b1, p, 1'b1, 1'b0, 1'b0, "R8");
    run_line(1'b0, p, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic test_backpressure; // R9
    line_t p = '{90, 12, 200, 45, 45, 180, 7, 99};
    run_line(1'b0, p, 1'b0, 1'b1, 1'b0, "");
    run_line(1'b1, p, 1'b0, 1'b1, 1'b0, "");
  endtask

  task automatic test_ignore_input; // R10: junk offered during emission
    line_t a = '{1, 2, 3, 4, 5, 6, 7, 8};
    line_t b = '{60, 61, 62, 63, 64, 65, 66, 67};
    run_line(1'b0, a, 1'b0, 1'b0, 1'b1, "");
    run_line(1'b0, b, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_down = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_up_ramp();
    test_up_edges();
    test_clip();
    test_down();
    test_mode_latch();
    test_backpressure();
    test_ignore_input();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule